// File: doc/BRIEF.md
# Timer event flag and mask unit

This block gathers eight timer events into one 8-bit status register and pairs it with an 8-bit interrupt-enable register of the same layout. Four output-compare match pulses, three input-capture edge pulses and one shared channel feed the flags. A mode input decides whether the shared channel is driven by a fourth capture edge or by a fifth compare match. Each event pulse sets its flag. Software clears a flag by writing a one to its bit. A single registered interrupt request is raised whenever some flag and its enable are both set.

A small synchronous bus port gives read and write access to both registers. The enable register sits at a base address and the flag register at the address right after it. With every enable bit at zero, software can poll the flags and no interrupt request is raised.

Top module: `tmr_evt_unit`

## Requirements
- R1: Both registers share one bit layout. From bit 7 down to bit 0 the bits are compare 1, compare 2, compare 3, compare 4, shared channel, capture 1, capture 2, capture 3. Each enable bit sits at the same position as its flag. On the ports, `oc_hit[0]` is compare 1 and `ic_edge[0]` is capture 1.
- R2: Reset clears the flag register, the enable register and the interrupt request to zero.
- R3: A bus write to the flag register clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: A one-cycle pulse on a compare-match input sets that channel's flag at the same clock edge.
- R5: A one-cycle pulse on a capture-edge input sets that channel's flag at the same clock edge.
- R6: When `shared_is_ic` is 1, bit 3 is set only by `ic4_edge` and `oc5_hit` has no effect. When it is 0, bit 3 is set only by `oc5_hit` and `ic4_edge` has no effect.
- R7: `irq` is the registered OR over all bits of (flag AND enable). It follows the register contents one clock later.
- R8: While the enable register is all zeros, `irq` stays low even when flags are set, and the flags can still be read.
- R9: The enable register is at address `ENA_ADDR`, which is 0 by default. The flag register is at `ENA_ADDR+1`. A write to one register never changes the other.
- R10: If a set pulse and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R11: Reads return the current register contents and change no state. `bus_rdata` is 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (1) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| oc_hit | input | 4 | Compare-match pulses; bit 0 is compare 1 |
| oc5_hit | input | 1 | Compare-5 match pulse for the shared channel |
| ic_edge | input | 3 | Capture-edge pulses; bit 0 is capture 1 |
| ic4_edge | input | 1 | Capture-4 edge pulse for the shared channel |
| shared_is_ic | input | 1 | Role of the shared channel: 1 = capture 4, 0 = compare 5 |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions run on every cycle and cover the following. Every event pulse must leave its flag set one edge later. A write-one clear with no competing event must remove the flag. No flag may rise without a source. The deselected shared source must never reach bit 3. `irq` must follow flag AND enable with one cycle of delay and must stay low while all enables are zero. The bench scenarios cover what only a sequence of bus accesses can show: the bit layout as software reads it, the address of each register, writes of zero leaving flags alone, reads with no side effects, the set-wins collision, and reset in the middle of a run.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
    localparam int unsigned OC_CNT  = 4;
    localparam int unsigned IC_CNT  = 3;
    localparam int unsigned EVT_W   = OC_CNT + 1 + IC_CNT;
    localparam int unsigned SHR_POS = IC_CNT;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_ENA  = 2'd1,
        ACC_FLG  = 2'd2
    } acc_tgt_e;
endpackage

// File: rtl/tmr_evt_src_map.sv
module tmr_evt_src_map #(
    parameter int unsigned OC_N = tmr_evt_pkg::OC_CNT,
    parameter int unsigned IC_N = tmr_evt_pkg::IC_CNT,
    localparam int unsigned W   = OC_N + 1 + IC_N
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OC_N-1:0] oc_hit,
    input  logic            oc5_hit,
    input  logic [IC_N-1:0] ic_edge,
    input  logic            ic4_edge,
    input  logic            shared_is_ic,
    output logic [W-1:0]    set_vec
);
    logic shared_set;

    always_comb begin
        if (shared_is_ic) shared_set = ic4_edge;
        else              shared_set = oc5_hit;
    end

    for (genvar i = 0; i < OC_N; i++) begin : g_oc
        assign set_vec[W-1-i] = oc_hit[i];
    end
    assign set_vec[IC_N] = shared_set;
    for (genvar j = 0; j < IC_N; j++) begin : g_ic
        assign set_vec[IC_N-1-j] = ic_edge[j];
    end

    // R6: the deselected source never reaches the shared bit
    a_r6_shared_ic_only: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_is_ic && !ic4_edge) |-> !set_vec[IC_N]);
    a_r6_shared_oc_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!shared_is_ic && !oc5_hit) |-> !set_vec[IC_N]);
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
    parameter int unsigned W = tmr_evt_pkg::EVT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);
    typedef struct packed {
        logic [W-1:0] flg;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a set pulse overrides a clear in the same cycle
        st_d.flg = (st_q.flg & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flg;

    // R4 and R5 and R10: every pulsed event is held after the edge
    a_r4_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
    // R3: a clear with no competing set removes the flag
    a_r3_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((flags & $past(clr_vec) & ~$past(set_vec)) == '0));
    // R5: no flag rises without a source pulse
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/tmr_evt_irq.sv
module tmr_evt_irq #(
    parameter int unsigned W = tmr_evt_pkg::EVT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags,
    input  logic [W-1:0] enables,
    output logic         irq
);
    typedef struct packed {
        logic req;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.req = |(flags & enables);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.req;

    // R7: request tracks masked flags one cycle later
    a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(flags & enables))));
    // R8: all enables clear means no request next cycle
    a_r8_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enables == '0) |=> !irq);
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit #(
    parameter int unsigned OC_N     = tmr_evt_pkg::OC_CNT,
    parameter int unsigned IC_N     = tmr_evt_pkg::IC_CNT,
    parameter int unsigned ADDR_W   = 1,
    parameter int unsigned ENA_ADDR = 0,
    localparam int unsigned W       = OC_N + 1 + IC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [OC_N-1:0]   oc_hit,
    input  logic              oc5_hit,
    input  logic [IC_N-1:0]   ic_edge,
    input  logic              ic4_edge,
    input  logic              shared_is_ic,
    output logic              irq
);
    import tmr_evt_pkg::*;

    localparam logic [ADDR_W-1:0] ENA_A = ADDR_W'(ENA_ADDR);
    localparam logic [ADDR_W-1:0] FLG_A = ADDR_W'(ENA_ADDR + 1);

    typedef struct packed {
        logic [W-1:0] ena;
    } ena_st_t;

    ena_st_t      st_d, st_q;
    acc_tgt_e     tgt;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;
    logic [W-1:0] flags;

    always_comb begin
        tgt = ACC_NONE;
        if (bus_sel) begin
            if (bus_addr == ENA_A)      tgt = ACC_ENA;
            else if (bus_addr == FLG_A) tgt = ACC_FLG;
        end
    end

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (bus_we && tgt == ACC_ENA) st_d.ena = bus_wdata;
        if (bus_we && tgt == ACC_FLG) clr_vec  = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_we) begin
            case (tgt)
                ACC_ENA: bus_rdata = st_q.ena;
                ACC_FLG: bus_rdata = flags;
                default: bus_rdata = '0;
            endcase
        end
    end

    tmr_evt_src_map #(.OC_N(OC_N), .IC_N(IC_N)) u_map (
        .clk(clk), .rst_n(rst_n), .oc_hit(oc_hit), .oc5_hit(oc5_hit),
        .ic_edge(ic_edge), .ic4_edge(ic4_edge), .shared_is_ic(shared_is_ic),
        .set_vec(set_vec)
    );

    tmr_evt_flags #(.W(W)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .flags(flags)
    );

    tmr_evt_irq #(.W(W)) u_irq (
        .clk(clk), .rst_n(rst_n), .flags(flags), .enables(st_q.ena), .irq(irq)
    );

    // R9: a flag-register write leaves the enables alone
    a_r9_enable_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt != ACC_ENA) |=> $stable(st_q.ena));
endmodule

// File: tb/tmr_evt_unit_tb.sv
`timescale 1ns/1ps
module tmr_evt_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [0:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] oc_hit = '0;
    logic       oc5_hit = 1'b0;
    logic [2:0] ic_edge = '0;
    logic       ic4_edge = 1'b0;
    logic       shared_is_ic = 1'b0;
    logic       irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tmr_evt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .oc_hit(oc_hit), .oc5_hit(oc5_hit), .ic_edge(ic_edge),
        .ic4_edge(ic4_edge), .shared_is_ic(shared_is_ic), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] oc, input logic o5, input logic [2:0] ic, input logic i4);
        @(negedge clk);
        oc_hit = oc; oc5_hit = o5; ic_edge = ic; ic4_edge = i4;
        @(negedge clk);
        oc_hit = '0; oc5_hit = 1'b0; ic_edge = '0; ic4_edge = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, v); check("R2 enables after reset", v, 8'h00);
        rd(1'b1, v); check("R2 flags after reset", v, 8'h00);
        check("R2 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_compare();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin
            pulse(4'(1 << i), 1'b0, 3'b0, 1'b0);
            rd(1'b1, v); check("R4 R1 compare flag position", v, 8'(8'h80 >> i));
            wr(1'b1, 8'h00);
            rd(1'b1, v); check("R3 zero write keeps flag", v, 8'(8'h80 >> i));
            wr(1'b1, 8'(8'h80 >> i));
            rd(1'b1, v); check("R3 one write clears flag", v, 8'h00);
        end
        pulse(4'b1010, 1'b0, 3'b0, 1'b0);
        wr(1'b1, 8'h40);
        rd(1'b1, v); check("R3 partial clear", v, 8'h10);
        wr(1'b1, 8'hFF);
    endtask

    task automatic t_capture();
        logic [7:0] v;
        for (int j = 0; j < 3; j++) begin
            pulse(4'b0, 1'b0, 3'(1 << j), 1'b0);
            rd(1'b1, v); check("R5 R1 capture flag position", v, 8'(8'h04 >> j));
            wr(1'b1, 8'hFF);
        end
        pulse(4'b0, 1'b0, 3'b111, 1'b0);
        rd(1'b1, v); check("R5 all captures together", v, 8'h07);
        wr(1'b1, 8'hFF);
    endtask

    task automatic t_shared();
        logic [7:0] v;
        shared_is_ic = 1'b1;
        pulse(4'b0, 1'b1, 3'b0, 1'b0);
        rd(1'b1, v); check("R6 compare5 ignored in capture mode", v, 8'h00);
        pulse(4'b0, 1'b0, 3'b0, 1'b1);
        rd(1'b1, v); check("R6 capture4 sets bit3", v, 8'h08);
        wr(1'b1, 8'h08);
        shared_is_ic = 1'b0;
        pulse(4'b0, 1'b0, 3'b0, 1'b1);
        rd(1'b1, v); check("R6 capture4 ignored in compare mode", v, 8'h00);
        pulse(4'b0, 1'b1, 3'b0, 1'b0);
        rd(1'b1, v); check("R6 compare5 sets bit3", v, 8'h08);
        wr(1'b1, 8'hFF);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        pulse(4'b0001, 1'b0, 3'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R8 no irq with enables clear", {7'b0, irq}, 8'h00);
        rd(1'b1, v); check("R8 flag visible for polling", v, 8'h80);
        wr(1'b0, 8'h80);
        check("R7 irq one cycle after enable", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R7 irq raised", {7'b0, irq}, 8'h01);
        wr(1'b0, 8'h40);
        @(negedge clk);
        check("R7 irq gated by mask", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h80);
        @(negedge clk);
        wr(1'b1, 8'h80);
        @(negedge clk);
        check("R7 irq drops after clear", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        pulse(4'b0001, 1'b0, 3'b0, 1'b0);
        @(negedge clk);
        oc_hit = 4'b0010;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'hC0;
        @(negedge clk);
        oc_hit = '0; bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        rd(1'b1, v); check("R10 set wins over clear", v, 8'h40);
        wr(1'b1, 8'hFF);
    endtask

    task automatic t_map();
        logic [7:0] v;
        pulse(4'b0100, 1'b0, 3'b010, 1'b0);
        wr(1'b0, 8'hA5);
        rd(1'b0, v); check("R9 enable register at base", v, 8'hA5);
        rd(1'b1, v); check("R9 enable write leaves flags", v, 8'h22);
        wr(1'b1, 8'h20);
        rd(1'b0, v); check("R9 flag write leaves enables", v, 8'hA5);
        rd(1'b1, v); check("R11 first read", v, 8'h02);
        rd(1'b1, v); check("R11 repeated read unchanged", v, 8'h02);
        @(negedge clk);
        #1 check("R11 rdata idle zero", bus_rdata, 8'h00);
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_midreset();
        logic [7:0] v;
        wr(1'b0, 8'hFF);
        pulse(4'b1111, 1'b0, 3'b111, 1'b0);
        @(negedge clk);
        check("R7 irq on before reset", {7'b0, irq}, 8'h01);
        t_reset();
        rd(1'b1, v); check("R2 flags cleared by reset", v, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_compare();
        t_capture();
        t_shared();
        t_irq();
        t_collide();
        t_map();
        t_midreset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule